// File: doc/BRIEF.md
# Vector Structure Load/Store Decoder

This block takes one 32-bit instruction word from the vector structure load/store class and turns it into decode fields, using only combinational logic. It recognises three access forms. The multiple-structure form moves whole registers. The single-lane form moves one element position of one to four registers. The load-and-replicate form copies one element into every position of one to four registers. For each access the block reports whether it is a load or a store, how many registers it touches, which lane it uses, the element width, the base and data register numbers, and how post-indexing is done.

When the immediate post-index form is used, the block also computes how many bytes the base register grows by. Encodings that the class leaves unallocated are flagged illegal, and an illegal word is never reported as valid. A word outside the class is neither valid nor illegal. An issue stage places the block in front of the memory pipe, which then uses the fields without decoding them again.

Top module: `simd_ls_decoder`

## Requirements
- R1: A word with bit 31 = 1, or with bits 29:25 not equal to 00110, drives both `valid_o` and `illegal_o` to 0.
- R2: `kind_o` is 0 (multiple-structure) when bit 24 = 0. It is 2 (replicate) when bit 24 = 1 and bits 15:14 = 11. It is 1 (single-lane) otherwise. `isLoad_o` follows bit 22. `baseReg_o` is bits 9:5 and `dataReg_o` is bits 4:0.
- R3: For the single-lane and replicate forms, `regCount_o` is the two-bit value {bit 13, bit 21} plus 1, so it ranges from 1 to 4.
- R4: Single-lane element size and lane index depend on bits 15:14. Element size is coded as 0 = byte, 1 = halfword, 2 = word, 3 = doubleword, and Q is bit 30, S is bit 12 and size is bits 11:10.
  - For 00: byte, and lane = {Q,S,size}.
  - For 01: halfword, and lane = {Q,S,size[1]}.
  - For 10 with size[0] = 0: word, and lane = {Q,S}.
  - For 10 with size[0] = 1: doubleword, and lane = Q.
- R5: A single-lane word is illegal in three cases: halfword group with size[0] = 1; group 10 with size[1] = 1; doubleword with S = 1.
- R6: The immediate increment for a single-lane access is register count × element bytes. For a replicate access it is register count << size field, so it is ({2,1}[bit 21]) << size for type 0xC and ({4,3}[bit 21]) << size for type 0xE.
- R7: For the multiple-structure form, type (bits 15:12) sets the register count as follows: 0 and 2 give 4, 4 and 6 give 3, 8 and 10 give 2, and 7 gives 1. The increment is 8 bytes per register, doubled when Q = 1. Every other type is illegal.
- R8: Three encodings are illegal: a multiple-structure word with bit 21 = 1, a replicate store, and a single-structure type of 0xD or 0xF.
- R9: When post-indexing (bit 23 = 1), a field value of 11111 in bits 20:16 selects the immediate increment. Any other value sets `incByReg_o` and forces `incBytes_o` to 0. Without post-indexing, `incBytes_o` is 0 and a nonzero field is illegal.
- R10: An illegal word drives `valid_o`, `isLoad_o`, `postIdx_o`, `incByReg_o` and `incBytes_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| valid_o | output | 1 | Word is in the class and legal |
| illegal_o | output | 1 | Word is in the class but unallocated |
| kind_o | output | 2 | 0 multiple, 1 single-lane, 2 replicate |
| isLoad_o | output | 1 | Load (qualified by valid) |
| regCount_o | output | 3 | Registers touched, 1 to 4 |
| laneIdx_o | output | 4 | Lane index (0 for non-lane forms) |
| elemSize_o | output | 2 | log2 of element bytes |
| baseReg_o | output | 5 | Base register number |
| dataReg_o | output | 5 | First data register number |
| postIdx_o | output | 1 | Post-index writeback (qualified) |
| incByReg_o | output | 1 | Increment comes from a register |
| incReg_o | output | 5 | Increment register number (raw field) |
| incBytes_o | output | 7 | Immediate post-increment in bytes |

## Verification
The bench builds the block with its default parameters: a 16-byte vector register and 5-bit register numbers. With these values the 4-bit lane index and 7-bit increment are at full width. The top lane of each element group, the 64-byte doubled multiple-structure increment and the 32-byte four-register doubleword replicate increment can therefore all be reached. Directed words then cover every lane group, both replicate types, the listed multiple-structure types and each illegal rule.

// File: rtl/simd_ls_pkg.sv
package simd_ls_pkg;

  typedef enum logic [1:0] {
    KIND_MULTI = 2'd0,
    KIND_LANE  = 2'd1,
    KIND_REPL  = 2'd2
  } acc_kind_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic       kindMulti;
    logic       kindLane;
    logic       kindRepl;
    logic       grpByte;
    logic       grpHalf;
    logic       grpWide;
    logic       incEn;
    logic [2:0] multiRegs;
  } dp_strobe_t;

endpackage

// File: rtl/simd_ls_ctrl.sv
module simd_ls_ctrl
  import simd_ls_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int REG_W   = 5
) (
  input  logic [INSTR_W-1:0] instr_i,
  output dp_strobe_t         strobe_o,
  output logic               valid_o,
  output logic               illegal_o,
  output logic [1:0]         kind_o,
  output logic               isLoad_o,
  output logic               postIdx_o,
  output logic               incByReg_o
);
  localparam logic [REG_W-1:0] IMM_SEL = {REG_W{1'b1}};

  logic             classMatch;
  logic             isSingle, isPost, isLoadBit, wideBit, sBit;
  logic [REG_W-1:0] incField;
  logic [3:0]       opType;
  logic [1:0]       sizeFld;
  logic             isRepl, isLane;
  logic [2:0]       multiRegs;
  logic             laneBad, replBad, multiBad, idxBad, unalloc;

  assign classMatch = ~instr_i[31] && (instr_i[29:25] == 5'b00110);
  assign isSingle   = instr_i[24];
  assign isPost     = instr_i[23];
  assign isLoadBit  = instr_i[22];
  assign wideBit    = instr_i[21];
  assign incField   = instr_i[16 +: REG_W];
  assign opType     = instr_i[15:12];
  assign sBit       = instr_i[12];
  assign sizeFld    = instr_i[11:10];

  assign isRepl = isSingle && (opType[3:2] == 2'b11);
  assign isLane = isSingle && !isRepl;

  always_comb begin
    case (opType)
      4'd0, 4'd2:  multiRegs = 3'd4;
      4'd4, 4'd6:  multiRegs = 3'd3;
      4'd8, 4'd10: multiRegs = 3'd2;
      4'd7:        multiRegs = 3'd1;
      default:     multiRegs = 3'd0;
    endcase
  end

  always_comb begin
    laneBad = 1'b0;
    case (opType[3:2])
      2'b01:   laneBad = sizeFld[0];
      2'b10:   laneBad = sizeFld[1] || (sizeFld[0] && sBit);
      default: laneBad = 1'b0;
    endcase
  end

  assign replBad  = opType[0] || !isLoadBit;
  assign multiBad = wideBit || (multiRegs == 3'd0);
  assign idxBad   = !isPost && (incField != '0);
  assign unalloc  = (!isSingle && multiBad) || (isLane && laneBad) ||
                    (isRepl && replBad) || idxBad;

  assign illegal_o  = classMatch && unalloc;
  assign valid_o    = classMatch && !unalloc;
  assign isLoad_o   = valid_o && isLoadBit;
  assign postIdx_o  = valid_o && isPost;
  assign incByReg_o = postIdx_o && (incField != IMM_SEL);

  always_comb begin
    if (isRepl)      kind_o = KIND_REPL;
    else if (isLane) kind_o = KIND_LANE;
    else             kind_o = KIND_MULTI;
  end

  always_comb begin
    strobe_o.kindMulti = !isSingle;
    strobe_o.kindLane  = isLane;
    strobe_o.kindRepl  = isRepl;
    strobe_o.grpByte   = isLane && (opType[3:2] == 2'b00);
    strobe_o.grpHalf   = isLane && (opType[3:2] == 2'b01);
    strobe_o.grpWide   = isLane && (opType[3:2] == 2'b10);
    strobe_o.incEn     = postIdx_o && !incByReg_o;
    strobe_o.multiRegs = multiRegs;
  end

  always_comb begin
    if (!$isunknown(instr_i)) begin
      // R8
      repl_is_load_chk: assert (!(valid_o && kind_o == KIND_REPL) || isLoad_o)
        else $error("replicate form reported as store");
      // R10
      illegal_quiet_chk: assert (!illegal_o || !(isLoad_o || postIdx_o || incByReg_o))
        else $error("illegal word leaked a qualified strobe");
    end
  end

endmodule

// File: rtl/simd_ls_datapath.sv
module simd_ls_datapath
  import simd_ls_pkg::*;
#(
  parameter int INSTR_W   = 32,
  parameter int VEC_BYTES = 16,
  parameter int LANE_W    = $clog2(VEC_BYTES),
  parameter int CNT_W     = 3,
  parameter int INC_W     = $clog2(VEC_BYTES * 4) + 1
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  dp_strobe_t         strobe_i,
  output logic [CNT_W-1:0]   regCount_o,
  output logic [LANE_W-1:0]  laneIdx_o,
  output logic [1:0]         elemSize_o,
  output logic [INC_W-1:0]   incBytes_o
);
  localparam int SHIFT_W = 3;

  logic             qBit, sBit;
  logic [1:0]       sizeFld;
  logic [CNT_W-1:0] singleCount;
  logic [3:0]       laneRaw;
  logic [SHIFT_W-1:0] shiftAmt;

  assign qBit    = instr_i[30];
  assign sBit    = instr_i[12];
  assign sizeFld = instr_i[11:10];

  assign singleCount = CNT_W'({instr_i[13], instr_i[21]}) + CNT_W'(1);
  assign regCount_o  = strobe_i.kindMulti ? strobe_i.multiRegs : singleCount;

  always_comb begin
    if (strobe_i.grpByte)      elemSize_o = 2'd0;
    else if (strobe_i.grpHalf) elemSize_o = 2'd1;
    else if (strobe_i.grpWide) elemSize_o = sizeFld[0] ? 2'd3 : 2'd2;
    else                       elemSize_o = sizeFld;
  end

  always_comb begin
    laneRaw = 4'd0;
    if (strobe_i.grpByte)      laneRaw = {qBit, sBit, sizeFld};
    else if (strobe_i.grpHalf) laneRaw = {1'b0, qBit, sBit, sizeFld[1]};
    else if (strobe_i.grpWide) laneRaw = sizeFld[0] ? {3'b000, qBit} : {2'b00, qBit, sBit};
  end

  generate
    if (LANE_W >= 4) begin : g_lane_wide
      assign laneIdx_o = LANE_W'(laneRaw);
    end else begin : g_lane_narrow
      assign laneIdx_o = laneRaw[LANE_W-1:0];
    end
  endgenerate

  assign shiftAmt   = strobe_i.kindMulti ? (SHIFT_W'(3) + SHIFT_W'(qBit))
                                         : SHIFT_W'(elemSize_o);
  assign incBytes_o = strobe_i.incEn ? (INC_W'(regCount_o) << shiftAmt) : '0;

  always_comb begin
    if (!$isunknown(instr_i) && strobe_i.kindLane) begin
      // R4
      lane_fits_chk: assert (((int'(laneIdx_o) + 1) << elemSize_o) <= VEC_BYTES)
        else $error("lane index beyond register width");
    end
  end

endmodule

// File: rtl/simd_ls_decoder.sv
module simd_ls_decoder
  import simd_ls_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int REG_W     = 5,
  parameter int LANE_W    = $clog2(VEC_BYTES),
  parameter int INC_W     = $clog2(VEC_BYTES * 4) + 1
) (
  input  logic [31:0]       instr_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [1:0]        kind_o,
  output logic              isLoad_o,
  output logic [2:0]        regCount_o,
  output logic [LANE_W-1:0] laneIdx_o,
  output logic [1:0]        elemSize_o,
  output logic [REG_W-1:0]  baseReg_o,
  output logic [REG_W-1:0]  dataReg_o,
  output logic              postIdx_o,
  output logic              incByReg_o,
  output logic [REG_W-1:0]  incReg_o,
  output logic [INC_W-1:0]  incBytes_o
);
  dp_strobe_t strobe;

  simd_ls_ctrl #(.INSTR_W(32), .REG_W(REG_W)) u_ctrl (
    .instr_i   (instr_i),
    .strobe_o  (strobe),
    .valid_o   (valid_o),
    .illegal_o (illegal_o),
    .kind_o    (kind_o),
    .isLoad_o  (isLoad_o),
    .postIdx_o (postIdx_o),
    .incByReg_o(incByReg_o)
  );

  simd_ls_datapath #(
    .INSTR_W(32), .VEC_BYTES(VEC_BYTES), .LANE_W(LANE_W), .CNT_W(3), .INC_W(INC_W)
  ) u_dp (
    .instr_i   (instr_i),
    .strobe_i  (strobe),
    .regCount_o(regCount_o),
    .laneIdx_o (laneIdx_o),
    .elemSize_o(elemSize_o),
    .incBytes_o(incBytes_o)
  );

  assign baseReg_o = instr_i[5 +: REG_W];
  assign dataReg_o = instr_i[0 +: REG_W];
  assign incReg_o  = instr_i[16 +: REG_W];

  always_comb begin
    if (!$isunknown(instr_i)) begin
      // R1
      flags_exclusive_chk: assert ($onehot0({valid_o, illegal_o}))
        else $error("valid and illegal both set");
      // R9
      imm_inc_nonzero_chk: assert (!(postIdx_o && !incByReg_o) || (incBytes_o != '0))
        else $error("immediate post-index with zero increment");
      // R7
      multi_lane_zero_chk: assert (!(valid_o && kind_o == KIND_MULTI) || (laneIdx_o == '0))
        else $error("multiple-structure form with nonzero lane");
      // R3
      count_range_chk: assert (!valid_o || (regCount_o >= 3'd1 && regCount_o <= 3'd4))
        else $error("register count out of range");
    end
  end

endmodule

// File: tb/simd_ls_decoder_bench.sv
module simd_ls_decoder_bench;
  logic        clk = 1'b0;
  logic [31:0] instr;
  logic        valid, illegal, isLoad, postIdx, incByReg;
  logic [1:0]  kind, elemSize;
  logic [2:0]  regCount;
  logic [3:0]  laneIdx;
  logic [4:0]  baseReg, dataReg, incReg;
  logic [6:0]  incBytes;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simd_ls_decoder u_simd_ls_decoder (
    .instr_i(instr), .valid_o(valid), .illegal_o(illegal), .kind_o(kind),
    .isLoad_o(isLoad), .regCount_o(regCount), .laneIdx_o(laneIdx),
    .elemSize_o(elemSize), .baseReg_o(baseReg), .dataReg_o(dataReg),
    .postIdx_o(postIdx), .incByReg_o(incByReg), .incReg_o(incReg),
    .incBytes_o(incBytes)
  );

  function automatic logic [31:0] mk(bit q, bit single, bit post, bit load, bit b21,
                                     logic [4:0] rm, logic [3:0] typ, logic [1:0] sz,
                                     logic [4:0] rn, logic [4:0] rt);
    return {1'b0, q, 5'b00110, single, post, load, b21, rm, typ, sz, rn, rt};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  task automatic expectIllegal(string req, logic [31:0] w);
    apply(w);
    chk(req, "illegal", illegal, 1);
    chk("R10", "valid", valid, 0);
    chk("R10", "isLoad", isLoad, 0);
    chk("R10", "postIdx", postIdx, 0);
    chk("R10", "incBytes", incBytes, 0);
  endtask

  task automatic test_unmatched();
    apply(32'h0);
    chk("R1", "valid zero word", valid, 0);
    chk("R1", "illegal zero word", illegal, 0);
    apply(mk(0,1,1,1,0,5'h1f,4'h0,2'b00,5'd1,5'd2) | 32'h8000_0000);
    chk("R1", "valid bit31", valid, 0);
    chk("R1", "illegal bit31", illegal, 0);
  endtask

  task automatic test_lane_byte();
    apply(mk(1,1,1,1,0,5'h1f,4'b0001,2'b11,5'd9,5'd17));
    chk("R2", "valid", valid, 1);
    chk("R2", "kind", kind, 1);
    chk("R2", "isLoad", isLoad, 1);
    chk("R2", "baseReg", baseReg, 9);
    chk("R2", "dataReg", dataReg, 17);
    chk("R4", "lane", laneIdx, 15);
    chk("R4", "elemSize", elemSize, 0);
    chk("R3", "regCount", regCount, 1);
    chk("R6", "incBytes", incBytes, 1);
  endtask

  task automatic test_lane_half();
    apply(mk(1,1,1,0,1,5'h1f,4'b0101,2'b10,5'd3,5'd4));
    chk("R2", "isLoad store", isLoad, 0);
    chk("R4", "lane", laneIdx, 7);
    chk("R4", "elemSize", elemSize, 1);
    chk("R3", "regCount", regCount, 2);
    chk("R6", "incBytes", incBytes, 4);
    expectIllegal("R5", mk(1,1,1,0,1,5'h1f,4'b0101,2'b01,5'd3,5'd4));
  endtask

  task automatic test_lane_word_double();
    apply(mk(1,1,1,1,1,5'h1f,4'b1011,2'b00,5'd0,5'd0));
    chk("R4", "word lane", laneIdx, 3);
    chk("R4", "word size", elemSize, 2);
    chk("R3", "regCount 4", regCount, 4);
    chk("R6", "word inc", incBytes, 16);
    apply(mk(1,1,1,1,0,5'h1f,4'b1010,2'b01,5'd0,5'd0));
    chk("R4", "double lane", laneIdx, 1);
    chk("R4", "double size", elemSize, 3);
    chk("R3", "regCount 3", regCount, 3);
    chk("R6", "double inc", incBytes, 24);
    expectIllegal("R5", mk(1,1,1,1,0,5'h1f,4'b1011,2'b01,5'd0,5'd0));
    expectIllegal("R5", mk(0,1,1,1,0,5'h1f,4'b1000,2'b10,5'd0,5'd0));
  endtask

  task automatic test_replicate();
    apply(mk(1,1,1,1,1,5'h1f,4'hC,2'b10,5'd0,5'd0));
    chk("R2", "kind repl", kind, 2);
    chk("R3", "repl count", regCount, 2);
    chk("R6", "repl C inc", incBytes, 8);
    chk("R4", "repl lane", laneIdx, 0);
    apply(mk(0,1,1,1,1,5'h1f,4'hE,2'b11,5'd0,5'd0));
    chk("R6", "repl E inc 4<<3", incBytes, 32);
    apply(mk(0,1,1,1,0,5'h1f,4'hE,2'b00,5'd0,5'd0));
    chk("R3", "repl E count", regCount, 3);
    chk("R6", "repl E inc 3", incBytes, 3);
    expectIllegal("R8", mk(0,1,1,0,0,5'h1f,4'hC,2'b00,5'd0,5'd0));
    expectIllegal("R8", mk(0,1,1,1,0,5'h1f,4'hD,2'b00,5'd0,5'd0));
  endtask

  task automatic test_multi();
    apply(mk(1,0,1,1,0,5'h1f,4'h0,2'b00,5'd0,5'd0));
    chk("R7", "kind", kind, 0);
    chk("R7", "type0 count", regCount, 4);
    chk("R7", "type0 Q inc", incBytes, 64);
    apply(mk(0,0,1,0,0,5'h1f,4'h7,2'b01,5'd0,5'd0));
    chk("R7", "type7 count", regCount, 1);
    chk("R7", "type7 inc", incBytes, 8);
    apply(mk(1,0,1,0,0,5'h1f,4'h6,2'b01,5'd0,5'd0));
    chk("R7", "type6 inc", incBytes, 48);
    expectIllegal("R7", mk(0,0,1,1,0,5'h1f,4'h1,2'b00,5'd0,5'd0));
    expectIllegal("R8", mk(0,0,1,1,1,5'h1f,4'h0,2'b00,5'd0,5'd0));
  endtask

  task automatic test_post_modes();
    apply(mk(0,1,1,1,0,5'd5,4'b0000,2'b00,5'd0,5'd0));
    chk("R9", "incByReg", incByReg, 1);
    chk("R9", "incReg", incReg, 5);
    chk("R9", "incBytes reg", incBytes, 0);
    apply(mk(0,1,0,1,0,5'd0,4'b0000,2'b00,5'd0,5'd0));
    chk("R9", "no post valid", valid, 1);
    chk("R9", "postIdx", postIdx, 0);
    chk("R9", "incBytes none", incBytes, 0);
    expectIllegal("R9", mk(0,1,0,1,0,5'd3,4'b0000,2'b00,5'd0,5'd0));
  endtask

  initial begin
    instr = 32'h0;
    test_unmatched();
    test_lane_byte();
    test_lane_half();
    test_lane_word_double();
    test_replicate();
    test_multi();
    test_post_modes();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule